// File: doc/BRIEF.md
# Receive Frame Channel Sorter and Splitter

This block takes the byte stream of frames arriving from the ring and steers every byte onto one of three indicate channels. Each channel is a byte lane of its own, with a valid strobe and an end-of-frame strobe. The channel for a frame is chosen from its frame-control byte and from two address-match flags. One flag reports that the station's own address matched. The other reports a match against an external (bridging) address table.

Two configuration inputs select the behaviour. Sorting mode sends externally matched frames to channel 2. Split mode cuts an ordinary frame after a programmed number of header bytes: the header goes to channel 1 and the rest of the frame goes to channel 2. Management frames (the MAC and SMT classes) always go to channel 0 and are never cut. Frames that match no address are discarded.

The channel decision, the header length and the split setting are taken on the first byte of a frame and held until its last byte. Every byte appears at the outputs one clock after it is presented.

Top module: `rxs_sorter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all bits of `ch_valid` and `ch_eof` are 0.
- R2: A frame is management class when frame-control bits 5:4 are 00 and bits 3:0 are not 0000; bit 7 set marks MAC and bit 7 clear marks SMT. A matched management frame that is not taken by R3 goes whole to channel 0.
- R3: With `cfg_sort_en`=1, a frame whose `in_ext_match` is 1 goes whole to channel 2, whatever its class and whatever the split setting.
- R4: A matched frame that is not management class and not taken by R3 goes whole to channel 1 when `cfg_split_en`=0 or `cfg_hdr_len`=0.
- R5: A frame with `in_int_match`=0 and `in_ext_match`=0 on its first byte puts no byte on any channel.
- R6: In split mode with a header length H>0, bytes 0..H-1 of an ordinary frame go to channel 1, counting the first (frame-control) byte as byte 0. All later bytes go to channel 2. Channel 1 raises its end flag on byte H-1 and channel 2 raises its end flag on the frame's last byte.
- R7: In split mode, when H is at least the frame length, the whole frame goes to channel 1, with its end flag on the frame's last byte.
- R8: Management frames are never split. In split mode they go whole to channel 0.
- R9: Each input byte appears, with its data, on at most one channel exactly one cycle after it is presented. An end flag is only ever raised together with that channel's valid.
- R10: The match flags, `cfg_sort_en`, `cfg_split_en` and `cfg_hdr_len` are sampled on the first byte of a frame; changes to them later in the frame have no effect. Valid bytes that arrive after a frame's last byte and before the next start flag are dropped. A start flag in the middle of a frame begins a new frame.
- R11: With `cfg_sort_en`=0, `in_ext_match` counts only as an address match, and the frame is routed by class as in R2, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sort_en | input | 1 | Send externally matched frames to channel 2 |
| cfg_split_en | input | 1 | Enable the header/body split |
| cfg_hdr_len | input | LW | Header length in bytes for the split |
| in_valid | input | 1 | Input byte is valid |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_data | input | DW | Input byte |
| in_fc | input | 8 | Frame-control byte, valid with the first byte |
| in_int_match | input | 1 | Station address matched, valid with the first byte |
| in_ext_match | input | 1 | External address matched, valid with the first byte |
| ch_valid | output | 3 | Per-channel byte valid |
| ch_eof | output | 3 | Per-channel end of frame |
| ch_data | output | 3 x DW | Per-channel byte |

## Verification
The assertions check these properties on every cycle:
- no byte appears on two lanes at once and no end flag appears without a valid;
- an idle input gives an idle output in the next cycle;
- the first byte of a frame lands on the lane that its class, match flags and mode call for (drop, channel 0, channel 2, or channel 1 as the first part of a split);
- a stray byte outside a frame produces nothing.

Some behaviours depend on where the bytes fall in a frame, and only the bench's scenarios can show them. These are the split point at H-1 and the end flag it raises, the case of a header length equal to or longer than the frame, and the freezing of configuration and match flags after the first byte. The bench also covers back-to-back frames and a start flag that restarts a frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int NCH = 3;

  typedef enum logic [2:0] {
    RT_DROP  = 3'd0,
    RT_CH0   = 3'd1,
    RT_CH1   = 3'd2,
    RT_CH2   = 3'd3,
    RT_SPLIT = 3'd4
  } route_e;

  // Management class: bits 5:4 clear and a nonzero low nibble (bit 7 picks MAC/SMT)
  function automatic logic is_mgmt(input logic [7:0] fc);
    return (fc[5:4] == 2'b00) && (fc[3:0] != 4'h0);
  endfunction

  function automatic route_e pick_route(input logic [7:0] fc, input logic int_m,
                                        input logic ext_m, input logic sort_en,
                                        input logic split_en, input logic hdr_zero);
    if (!(int_m || ext_m))        return RT_DROP;
    else if (sort_en && ext_m)    return RT_CH2;
    else if (is_mgmt(fc))         return RT_CH0;
    else if (split_en && !hdr_zero) return RT_SPLIT;
    else                          return RT_CH1;
  endfunction

  function automatic logic [1:0] lane_of(input route_e r, input logic in_hdr);
    case (r)
      RT_CH0:   return 2'd0;
      RT_CH1:   return 2'd1;
      RT_CH2:   return 2'd2;
      RT_SPLIT: return in_hdr ? 2'd1 : 2'd2;
      default:  return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [7:0]    fc,
  input  logic          int_match,
  input  logic          ext_match,
  input  logic          sort_en,
  input  logic          split_en,
  input  logic [LW-1:0] hdr_len,
  output route_e        route,
  output logic          mgmt
);

  logic hdr_zero;

  assign hdr_zero = (hdr_len == '0);
  assign mgmt     = is_mgmt(fc);
  assign route    = pick_route(fc, int_match, ext_match, sort_en, split_en, hdr_zero);

endmodule

// File: rtl/rxs_track.sv
module rxs_track
  import rxs_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  route_e        new_route,
  input  logic [LW-1:0] cfg_hdr_len,
  output logic          byte_go,
  output logic [1:0]    byte_lane,
  output logic          byte_last,
  output logic          frame_active
);

  logic          active_q;
  route_e        route_q;
  logic [LW-1:0] hdr_q;
  logic [LW-1:0] cnt_q;

  logic          start;
  logic          live;
  route_e        eff_route;
  logic [LW-1:0] eff_hdr;
  logic [LW-1:0] eff_cnt;
  logic          in_hdr;
  logic          hdr_last;

  assign start     = in_valid && in_sof;
  assign live      = in_valid && (start || active_q);
  assign eff_route = start ? new_route : route_q;
  assign eff_hdr   = start ? cfg_hdr_len : hdr_q;
  assign eff_cnt   = start ? '0 : cnt_q;
  assign in_hdr    = (eff_cnt < eff_hdr);
  assign hdr_last  = (eff_route == RT_SPLIT) &&
                     (({1'b0, eff_cnt} + 1'b1) == {1'b0, eff_hdr});

  assign byte_go      = live && (eff_route != RT_DROP);
  assign byte_lane    = lane_of(eff_route, in_hdr);
  assign byte_last    = in_eof || hdr_last;
  assign frame_active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      route_q  <= RT_DROP;
      hdr_q    <= '0;
      cnt_q    <= '0;
    end else if (live) begin
      active_q <= !in_eof;
      route_q  <= eff_route;
      hdr_q    <= eff_hdr;
      cnt_q    <= in_hdr ? eff_cnt + 1'b1 : eff_cnt;
    end
  end

endmodule

// File: rtl/rxs_lane.sv
module rxs_lane #(
  parameter int DW  = 8,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_go,
  input  logic [1:0]    byte_lane,
  input  logic          byte_last,
  input  logic [DW-1:0] byte_data,
  output logic          lane_valid,
  output logic          lane_eof,
  output logic [DW-1:0] lane_data
);

  logic hit;

  assign hit = byte_go && (byte_lane == 2'(IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_valid <= 1'b0;
      lane_eof   <= 1'b0;
      lane_data  <= '0;
    end else begin
      lane_valid <= hit;
      lane_eof   <= hit && byte_last;
      if (hit) lane_data <= byte_data;
    end
  end

endmodule

// File: rtl/rxs_sorter.sv
module rxs_sorter
  import rxs_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_sort_en,
  input  logic                    cfg_split_en,
  input  logic [LW-1:0]           cfg_hdr_len,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [DW-1:0]           in_data,
  input  logic [7:0]              in_fc,
  input  logic                    in_int_match,
  input  logic                    in_ext_match,
  output logic [NCH-1:0]          ch_valid,
  output logic [NCH-1:0]          ch_eof,
  output logic [NCH-1:0][DW-1:0]  ch_data
);

  route_e     new_route;
  logic       fc_mgmt;
  logic       byte_go;
  logic [1:0] byte_lane;
  logic       byte_last;
  logic       frame_active;

  rxs_classify #(.LW(LW)) u_cls (
    .fc        (in_fc),
    .int_match (in_int_match),
    .ext_match (in_ext_match),
    .sort_en   (cfg_sort_en),
    .split_en  (cfg_split_en),
    .hdr_len   (cfg_hdr_len),
    .route     (new_route),
    .mgmt      (fc_mgmt)
  );

  rxs_track #(.LW(LW)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .new_route    (new_route),
    .cfg_hdr_len  (cfg_hdr_len),
    .byte_go      (byte_go),
    .byte_lane    (byte_lane),
    .byte_last    (byte_last),
    .frame_active (frame_active)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    rxs_lane #(.DW(DW), .IDX(g)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_go    (byte_go),
      .byte_lane  (byte_lane),
      .byte_last  (byte_last),
      .byte_data  (in_data),
      .lane_valid (ch_valid[g]),
      .lane_eof   (ch_eof[g]),
      .lane_data  (ch_data[g])
    );
  end

endmodule

// File: rtl/rxs_sorter_chk.sv
module rxs_sorter_chk
  import rxs_pkg::*;
#(
  parameter int LW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_sort_en,
  input logic           cfg_split_en,
  input logic [LW-1:0]  cfg_hdr_len,
  input logic           in_valid,
  input logic           in_sof,
  input logic [7:0]     in_fc,
  input logic           in_int_match,
  input logic           in_ext_match,
  input logic [NCH-1:0] ch_valid,
  input logic [NCH-1:0] ch_eof,
  input logic           frame_active,
  input logic           fc_mgmt
);

  logic first, matched, ext_taken;

  assign first     = in_valid && in_sof;
  assign matched   = in_int_match || in_ext_match;
  assign ext_taken = cfg_sort_en && in_ext_match;

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_valid)); // R9

  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_eof & ~ch_valid) == '0); // R9

  AST_IDLE_IN_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ch_valid == '0); // R9

  AST_NO_MATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    first && !matched |=> ch_valid == '0); // R5

  AST_EXT_TO_CH2: assert property (@(posedge clk) disable iff (!rst_n)
    first && ext_taken |=> ch_valid == 3'b100); // R3

  AST_MGMT_TO_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    first && matched && !ext_taken && (in_fc[5:4] == 2'b00) && (in_fc[3:0] != 4'h0)
    |=> ch_valid == 3'b001); // R8

  AST_SPLIT_HEAD_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    first && matched && !ext_taken && !fc_mgmt && cfg_split_en && (cfg_hdr_len != '0)
    |=> ch_valid == 3'b010); // R6

  AST_STRAY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sof && !frame_active |=> ch_valid == '0); // R10

endmodule

bind rxs_sorter rxs_sorter_chk #(.LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_sort_en  (cfg_sort_en),
  .cfg_split_en (cfg_split_en),
  .cfg_hdr_len  (cfg_hdr_len),
  .in_valid     (in_valid),
  .in_sof       (in_sof),
  .in_fc        (in_fc),
  .in_int_match (in_int_match),
  .in_ext_match (in_ext_match),
  .ch_valid     (ch_valid),
  .ch_eof       (ch_eof),
  .frame_active (frame_active),
  .fc_mgmt      (fc_mgmt)
);

// File: tb/sim_rxs_sorter.sv
module sim_rxs_sorter;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_sort_en = 1'b0;
  logic            cfg_split_en = 1'b0;
  logic [7:0]      cfg_hdr_len = 8'd0;
  logic            in_valid = 1'b0;
  logic            in_sof = 1'b0;
  logic            in_eof = 1'b0;
  logic [7:0]      in_data = 8'd0;
  logic [7:0]      in_fc = 8'd0;
  logic            in_int_match = 1'b0;
  logic            in_ext_match = 1'b0;
  logic [2:0]      ch_valid;
  logic [2:0]      ch_eof;
  logic [2:0][7:0] ch_data;

  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  rxs_sorter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sort_en(cfg_sort_en), .cfg_split_en(cfg_split_en),
    .cfg_hdr_len(cfg_hdr_len), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_fc(in_fc), .in_int_match(in_int_match),
    .in_ext_match(in_ext_match), .ch_valid(ch_valid), .ch_eof(ch_eof), .ch_data(ch_data)
  );

  // Reference model: where each byte should land, restated from the requirements
  logic [2:0] m_valid = 3'b0;
  logic [2:0] m_eof = 3'b0;
  logic [7:0] m_data [3];
  bit         m_active = 1'b0;
  int         m_kind = 0;   // 0 drop, 1..3 whole to lane kind-1, 4 split
  int         m_cnt = 0;
  int         m_hdr = 0;

  function automatic int expect_kind(input logic [7:0] fc, input logic im, input logic em,
                                     input logic srt, input logic spl, input int hl);
    bit mg;
    mg = ((fc & 8'h30) == 8'h00) && ((fc & 8'h0F) != 8'h00);
    if (!im && !em) return 0;
    if (srt && em)  return 3;
    if (mg)         return 1;
    if (spl && hl > 0) return 4;
    return 2;
  endfunction

  always @(posedge clk) begin
    m_valid = 3'b0;
    m_eof   = 3'b0;
    if (!rst_n) begin
      m_active = 1'b0;
    end else if (in_valid) begin
      if (in_sof) begin
        m_active = 1'b1;
        m_cnt    = 0;
        m_hdr    = int'(cfg_hdr_len);
        m_kind   = expect_kind(in_fc, in_int_match, in_ext_match, cfg_sort_en,
                               cfg_split_en, int'(cfg_hdr_len));
      end
      if (m_active) begin
        int lane;
        lane = -1;
        if (m_kind >= 1 && m_kind <= 3) lane = m_kind - 1;
        else if (m_kind == 4) lane = (m_cnt < m_hdr) ? 1 : 2;
        if (lane >= 0) begin
          m_valid[lane] = 1'b1;
          m_data[lane]  = in_data;
          m_eof[lane]   = in_eof || (m_kind == 4 && lane == 1 && m_cnt + 1 == m_hdr);
        end
        m_cnt++;
        if (in_eof) m_active = 1'b0;
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit bad;
      bad = (ch_valid !== m_valid) || (ch_eof !== m_eof);
      for (int c = 0; c < 3; c++)
        if (m_valid[c] && ch_data[c] !== m_data[c]) bad = 1'b1;
      n_tests++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: valid=%b eof=%b data=%h/%h/%h exp valid=%b eof=%b data=%h/%h/%h",
                 cur_req, ch_valid, ch_eof, ch_data[2], ch_data[1], ch_data[0],
                 m_valid, m_eof, m_data[2], m_data[1], m_data[0]);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
  endtask

  // twist: after the first byte, flip the match flags and the configuration (R10)
  task automatic frame(input logic [7:0] fc, input logic im, input logic em,
                       input int len, input logic [7:0] seed, input bit twist, input int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = seed + 8'(i);
      in_fc    = fc;
      if (i == 0) begin
        in_int_match = im; in_ext_match = em;
      end else begin
        in_int_match = !im; in_ext_match = !em;
        if (twist) begin
          cfg_sort_en  = !cfg_sort_en;
          cfg_split_en = !cfg_split_en;
          cfg_hdr_len  = cfg_hdr_len + 8'd2;
        end
      end
    end
    idle(gap);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: timed out, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      done = 1'b1;
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // Sorting mode
    cfg_sort_en = 1'b1;
    cur_req = "R3"; frame(8'h50, 1'b0, 1'b1, 6, 8'h10, 1'b0, 2);   // ordinary, external
    cur_req = "R3"; frame(8'hC1, 1'b1, 1'b1, 4, 8'h20, 1'b0, 2);   // MAC, external wins
    cur_req = "R2"; frame(8'hC1, 1'b1, 1'b0, 5, 8'h30, 1'b0, 2);   // MAC internal
    cur_req = "R2"; frame(8'h41, 1'b1, 1'b0, 3, 8'h38, 1'b0, 2);   // SMT internal
    cur_req = "R4"; frame(8'h50, 1'b1, 1'b0, 7, 8'h40, 1'b0, 2);   // ordinary internal
    cur_req = "R2"; frame(8'h40, 1'b1, 1'b0, 3, 8'h48, 1'b0, 2);   // low nibble zero: ordinary
    cur_req = "R5"; frame(8'h50, 1'b0, 1'b0, 5, 8'h50, 1'b0, 2);   // no match
    cur_req = "R5"; frame(8'hC2, 1'b0, 1'b0, 3, 8'h58, 1'b0, 2);

    // Split mode
    cfg_sort_en = 1'b0; cfg_split_en = 1'b1; cfg_hdr_len = 8'd3;
    cur_req = "R6"; frame(8'h50, 1'b1, 1'b0, 8, 8'h60, 1'b0, 2);
    cfg_hdr_len = 8'd1;
    cur_req = "R6"; frame(8'h51, 1'b1, 1'b0, 4, 8'h70, 1'b0, 2);
    cfg_hdr_len = 8'd0;
    cur_req = "R4"; frame(8'h50, 1'b1, 1'b0, 5, 8'h78, 1'b0, 2);
    cfg_hdr_len = 8'd10;
    cur_req = "R7"; frame(8'h50, 1'b1, 1'b0, 5, 8'h80, 1'b0, 2);
    cfg_hdr_len = 8'd5;
    cur_req = "R7"; frame(8'h50, 1'b1, 1'b0, 5, 8'h88, 1'b0, 2);   // H equals length
    cfg_hdr_len = 8'd2;
    cur_req = "R8"; frame(8'hC3, 1'b1, 1'b0, 6, 8'h90, 1'b0, 2);
    cur_req = "R8"; frame(8'h4F, 1'b1, 1'b0, 4, 8'h98, 1'b0, 2);
    cur_req = "R11"; frame(8'h50, 1'b0, 1'b1, 6, 8'hA0, 1'b0, 2);  // external, sort off
    cur_req = "R6"; frame(8'h50, 1'b1, 1'b0, 1, 8'hA8, 1'b0, 2);   // one-byte frame

    // Mid-frame changes ignored
    cfg_sort_en = 1'b0; cfg_split_en = 1'b1; cfg_hdr_len = 8'd2;
    cur_req = "R10"; frame(8'h50, 1'b1, 1'b0, 7, 8'hB0, 1'b1, 2);
    cfg_sort_en = 1'b0; cfg_split_en = 1'b1; cfg_hdr_len = 8'd3;
    cur_req = "R10"; frame(8'h50, 1'b0, 1'b0, 5, 8'hB8, 1'b1, 2);  // dropped stays dropped
    cfg_sort_en = 1'b0; cfg_split_en = 1'b0; cfg_hdr_len = 8'd2;

    // Stray bytes outside a frame
    cur_req = "R10";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hE0 + 8'(i);
    end
    idle(2);

    // Back-to-back frames and a restarting start flag
    cfg_split_en = 1'b1; cfg_hdr_len = 8'd2;
    cur_req = "R9"; frame(8'h50, 1'b1, 1'b0, 4, 8'hC0, 1'b0, 0);
    cur_req = "R9"; frame(8'hC1, 1'b1, 1'b0, 3, 8'hC8, 1'b0, 0);
    cur_req = "R9"; frame(8'h50, 1'b1, 1'b0, 3, 8'hD0, 1'b0, 1);
    cur_req = "R10";
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = 8'hF0; in_fc = 8'h50;
    in_int_match = 1'b1; in_ext_match = 1'b0;
    @(negedge clk);
    in_sof = 1'b0; in_data = 8'hF1;
    frame(8'hC1, 1'b1, 1'b0, 3, 8'hF8, 1'b0, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule